// File: doc/BRIEF.md
# FP32 Operand and Result Modifier Stage

This block sits beside the arithmetic core of a vector ALU that works on single-precision floats. On the input side it conditions up to three raw source operands: each operand can have its sign cleared (magnitude), flipped (negation), or both, which yields the negated magnitude. On the output side it conditions the raw result coming back from the arithmetic core: an optional power-of-two scale (times 2, times 4 or times one half) followed by an optional saturation into the closed interval 0.0 to 1.0.

All controls come straight from instruction bit-fields: a per-operand magnitude mask, a per-operand negation mask, a 2-bit scale code and a saturate bit. The modified operands and the final result are captured in one register stage, and a valid flag travels alongside with the same one-cycle delay. Scaling only touches the exponent field, so it costs an adder and two comparisons instead of a multiplier.

Top module: `fpmod_stage`

## Requirements
- R1: While rst_ni is low, out_valid_o, every lane of src_o and res_o are all zero.
- R2: out_valid_o equals the value in_valid_i had at the previous rising clock edge; data outputs reflect inputs captured at that edge.
- R3: When bit k of abs_i is set (and bit k of neg_i is clear), bit 31 of operand lane k (src_i bits 32k+31..32k) is cleared on src_o; other lanes are not affected.
- R4: When bit k of neg_i is set, bit 31 of lane k is inverted, or forced to one if bit k of abs_i is also set; bits 30..0 of every lane always pass unchanged, NaN payloads included.
- R5: With omod_i = 0 and clamp_i = 0, res_o equals res_i bit for bit, subnormals included.
- R6: For a normal res_i, omod_i = 1, 2, 3 adds +1, +2, -1 to the exponent field (bits 30..23) and keeps sign and mantissa.
- R7: If the scaled exponent reaches 255 or more, res_o is infinity with the sign of res_i.
- R8: If the scaled exponent reaches 0 or less, res_o is a zero with the sign of res_i; with a non-zero omod_i a subnormal res_i also becomes that signed zero.
- R9: With a non-zero omod_i, a zero, infinity or NaN res_i passes unchanged.
- R10: With clamp_i = 1, a NaN or any value with bit 31 set becomes 0x00000000, a value above 0x3F800000 (1.0, +infinity included) becomes 0x3F800000, and anything else passes.
- R11: Scaling is applied before clamping when both are enabled.
- R12: While in_valid_i is low, src_o and res_o keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input data valid |
| src_i | input | 96 | Raw operands, lane k at bits 32k+31..32k |
| abs_i | input | 3 | Magnitude mask, bit k for lane k |
| neg_i | input | 3 | Negation mask, bit k for lane k |
| omod_i | input | 2 | Scale code: 0 none, 1 times 2, 2 times 4, 3 times 0.5 |
| clamp_i | input | 1 | Saturate result to 0.0..1.0 |
| res_i | input | 32 | Raw result from the arithmetic core |
| out_valid_o | output | 1 | Output valid, one cycle after in_valid_i |
| src_o | output | 96 | Modified operands |
| res_o | output | 32 | Scaled and clamped result |

## Verification
The assertions watch, on every cycle, the valid delay, the fact that operand bits below the sign always pass through, the sign produced by the magnitude and negate-magnitude controls, the bit-exact pass-through of an unscaled unclamped result, the range of a clamped result, and the hold of the data registers while no valid input arrives. The exact exponent arithmetic of the scale codes, the saturation to infinity and flush to signed zero, the treatment of subnormals and specials, and the ordering of scale before clamp depend on specific values and are shown only by the bench's directed scenarios.

// File: rtl/fpmod_pkg.sv
package fpmod_pkg;

  typedef enum logic [1:0] {
    OMOD_NONE = 2'd0,
    OMOD_MUL2 = 2'd1,
    OMOD_MUL4 = 2'd2,
    OMOD_DIV2 = 2'd3
  } omod_e;

  localparam int unsigned FP_EXP_W = 8;
  localparam int unsigned FP_MAN_W = 23;

endpackage

// File: rtl/fpmod_src_mod.sv
// Sign-only operand modifier for one lane: magnitude first, then negation.
module fpmod_src_mod #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_i,
  input  logic             abs_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] op_o
);

  logic sign_mag;

  always_comb begin
    sign_mag = abs_i ? 1'b0 : op_i[WIDTH-1];
    op_o     = {sign_mag ^ neg_i, op_i[WIDTH-2:0]};
  end

endmodule

// File: rtl/fpmod_scale.sv
// Power-of-two result scaling through the exponent field.
module fpmod_scale
  import fpmod_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned WIDTH = 1 + EXP_W + MAN_W
) (
  input  logic [WIDTH-1:0] val_i,
  input  omod_e            omod_i,
  output logic [WIDTH-1:0] val_o
);

  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam int unsigned EXT_W = EXP_W + 2;

  logic                    sign;
  logic [EXP_W-1:0]        exp_f;
  logic [MAN_W-1:0]        man_f;
  logic signed [EXT_W-1:0] step;
  logic signed [EXT_W-1:0] exp_new;

  assign sign  = val_i[WIDTH-1];
  assign exp_f = val_i[WIDTH-2:MAN_W];
  assign man_f = val_i[MAN_W-1:0];

  always_comb begin
    unique case (omod_i)
      OMOD_MUL2: step = EXT_W'(1);
      OMOD_MUL4: step = EXT_W'(2);
      OMOD_DIV2: step = -EXT_W'(1);
      default:   step = '0;
    endcase
    exp_new = $signed({2'b00, exp_f}) + step;
  end

  always_comb begin
    if (omod_i == OMOD_NONE || exp_f == EXP_MAX) begin
      val_o = val_i;                              // unscaled, or inf/NaN
    end else if (exp_f == '0) begin
      val_o = {sign, {(WIDTH-1){1'b0}}};          // zero stays, subnormal flushed
    end else if (exp_new >= $signed({2'b00, EXP_MAX})) begin
      val_o = {sign, EXP_MAX, {MAN_W{1'b0}}};
    end else if (exp_new <= 0) begin
      val_o = {sign, {(WIDTH-1){1'b0}}};
    end else begin
      val_o = {sign, exp_new[EXP_W-1:0], man_f};
    end
  end

endmodule

// File: rtl/fpmod_clamp.sv
// Saturation of a float into [0.0, 1.0].
module fpmod_clamp #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23,
  localparam int unsigned WIDTH = 1 + EXP_W + MAN_W
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] val_o
);

  localparam logic [WIDTH-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic is_nan;
  logic above_one;

  assign is_nan    = (val_i[WIDTH-2:MAN_W] == '1) && (val_i[MAN_W-1:0] != '0);
  assign above_one = val_i[WIDTH-2:0] > ONE[WIDTH-2:0];

  always_comb begin
    if (!en_i)                       val_o = val_i;
    else if (is_nan || val_i[WIDTH-1]) val_o = '0;
    else if (above_one)              val_o = ONE;
    else                             val_o = val_i;
  end

endmodule

// File: rtl/fpmod_stage.sv
module fpmod_stage
  import fpmod_pkg::*;
#(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned EXP_W   = FP_EXP_W,
  parameter int unsigned MAN_W   = FP_MAN_W,
  localparam int unsigned WIDTH  = 1 + EXP_W + MAN_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [NUM_SRC*WIDTH-1:0] src_i,
  input  logic [NUM_SRC-1:0]       abs_i,
  input  logic [NUM_SRC-1:0]       neg_i,
  input  logic [1:0]               omod_i,
  input  logic                     clamp_i,
  input  logic [WIDTH-1:0]         res_i,
  output logic                     out_valid_o,
  output logic [NUM_SRC*WIDTH-1:0] src_o,
  output logic [WIDTH-1:0]         res_o
);

  logic [NUM_SRC*WIDTH-1:0] src_mod;
  logic [WIDTH-1:0]         res_scaled;
  logic [WIDTH-1:0]         res_final;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lane
    fpmod_src_mod #(
      .WIDTH (WIDTH)
    ) i_src_mod (
      .op_i  (src_i[k*WIDTH +: WIDTH]),
      .abs_i (abs_i[k]),
      .neg_i (neg_i[k]),
      .op_o  (src_mod[k*WIDTH +: WIDTH])
    );
  end

  fpmod_scale #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
  ) i_scale (
    .val_i  (res_i),
    .omod_i (omod_e'(omod_i)),
    .val_o  (res_scaled)
  );

  fpmod_clamp #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
  ) i_clamp (
    .val_i (res_scaled),
    .en_i  (clamp_i),
    .val_o (res_final)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      src_o       <= '0;
      res_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        src_o <= src_mod;
        res_o <= res_final;
      end
    end
  end

endmodule

// File: rtl/fpmod_stage_chk.sv
module fpmod_stage_chk #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned WIDTH   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     in_valid_i,
  input logic [NUM_SRC*WIDTH-1:0] src_i,
  input logic [NUM_SRC-1:0]       abs_i,
  input logic [NUM_SRC-1:0]       neg_i,
  input logic [1:0]               omod_i,
  input logic                     clamp_i,
  input logic [WIDTH-1:0]         res_i,
  input logic                     out_valid_o,
  input logic [NUM_SRC*WIDTH-1:0] src_o,
  input logic [WIDTH-1:0]         res_o
);

  localparam logic [WIDTH-2:0] ONE_MAG = {1'b0, {(WIDTH-MAN_GUESS-2){1'b1}}, {MAN_GUESS{1'b0}}};
  localparam int unsigned MAN_GUESS = WIDTH - 9;

  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_r1: assert (!out_valid_o && src_o == '0 && res_o == '0);
  end

  p_valid_delay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen |-> out_valid_o == $past(in_valid_i));

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_lane_chk
    p_low_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(in_valid_i) |->
        src_o[k*WIDTH +: WIDTH-1] == $past(src_i[k*WIDTH +: WIDTH-1]));
    p_abs_sign_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(in_valid_i && abs_i[k] && !neg_i[k]) |-> !src_o[k*WIDTH+WIDTH-1]);
    p_neg_abs_sign_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen && $past(in_valid_i && abs_i[k] && neg_i[k]) |-> src_o[k*WIDTH+WIDTH-1]);
  end

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(in_valid_i && omod_i == 2'd0 && !clamp_i) |-> res_o == $past(res_i));

  p_clamp_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(in_valid_i && clamp_i) |-> !res_o[WIDTH-1] && res_o[WIDTH-2:0] <= ONE_MAG);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && !$past(in_valid_i) |-> $stable(res_o) && $stable(src_o));

endmodule

bind fpmod_stage fpmod_stage_chk #(
  .NUM_SRC (NUM_SRC),
  .WIDTH   (WIDTH)
) i_fpmod_stage_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .src_i       (src_i),
  .abs_i       (abs_i),
  .neg_i       (neg_i),
  .omod_i      (omod_i),
  .clamp_i     (clamp_i),
  .res_i       (res_i),
  .out_valid_o (out_valid_o),
  .src_o       (src_o),
  .res_o       (res_o)
);

// File: tb/test_fpmod_stage.sv
`timescale 1ns/1ps
module test_fpmod_stage;

  localparam int unsigned W = 32;
  localparam int unsigned N = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           in_valid_i;
  logic [N*W-1:0] src_i;
  logic [N-1:0]   abs_i;
  logic [N-1:0]   neg_i;
  logic [1:0]     omod_i;
  logic           clamp_i;
  logic [W-1:0]   res_i;
  logic           out_valid_o;
  logic [N*W-1:0] src_o;
  logic [W-1:0]   res_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk_i = ~clk_i;

  fpmod_stage i_fpmod_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .src_i       (src_i),
    .abs_i       (abs_i),
    .neg_i       (neg_i),
    .omod_i      (omod_i),
    .clamp_i     (clamp_i),
    .res_i       (res_i),
    .out_valid_o (out_valid_o),
    .src_o       (src_o),
    .res_o       (res_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Drive one valid beat at a falling edge; outputs are checked at the next falling edge.
  task automatic beat(input logic [W-1:0] s0, s1, s2, input logic [N-1:0] a, ng,
                      input logic [1:0] om, input logic cl, input logic [W-1:0] r);
    @(negedge clk_i);
    in_valid_i = 1'b1;
    src_i = {s2, s1, s0};
    abs_i = a; neg_i = ng; omod_i = om; clamp_i = cl; res_i = r;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic res_case(input string req, input logic [1:0] om, input logic cl,
                          input logic [W-1:0] r, input logic [W-1:0] exp);
    beat('0, '0, '0, '0, '0, om, cl, r);
    chk(req, res_o, exp);
  endtask

  task automatic t_reset;
    chk("R1 valid", {31'd0, out_valid_o}, '0);
    chk("R1 res", res_o, '0);
    for (int k = 0; k < N; k++) chk("R1 src", src_o[k*W +: W], '0);
  endtask

  task automatic t_valid;
    beat(32'h1, 32'h2, 32'h3, '0, '0, 2'd0, 1'b0, 32'h4);
    chk("R2 valid high", {31'd0, out_valid_o}, 32'd1);
    chk("R2 data", res_o, 32'h4);
    @(negedge clk_i);
    chk("R2 valid low", {31'd0, out_valid_o}, 32'd0);
  endtask

  task automatic t_abs;
    beat(32'hC0000000, 32'hBF800000, 32'h40400000, 3'b101, 3'b000, 2'd0, 1'b0, '0);
    chk("R3 lane0", src_o[0*W +: W], 32'h40000000);
    chk("R3 lane1 untouched", src_o[1*W +: W], 32'hBF800000);
    chk("R3 lane2", src_o[2*W +: W], 32'h40400000);
  endtask

  task automatic t_neg;
    beat(32'h3F800000, 32'hC0000000, 32'h7FC00123, 3'b010, 3'b111, 2'd0, 1'b0, '0);
    chk("R4 neg pos", src_o[0*W +: W], 32'hBF800000);
    chk("R4 abs+neg", src_o[1*W +: W], 32'hC0000000);
    chk("R4 nan payload", src_o[2*W +: W], 32'hFFC00123);
    beat(32'h80000000, 32'hBF000000, 32'h12345678, 3'b100, 3'b011, 2'd0, 1'b0, '0);
    chk("R4 neg -0", src_o[0*W +: W], 32'h00000000);
    chk("R4 neg negative", src_o[1*W +: W], 32'h3F000000);
    chk("R3 abs only lane2", src_o[2*W +: W], 32'h12345678);
  endtask

  task automatic t_pass;
    res_case("R5 pattern", 2'd0, 1'b0, 32'h12345678, 32'h12345678);
    res_case("R5 subnormal", 2'd0, 1'b0, 32'h80000001, 32'h80000001);
    res_case("R5 nan", 2'd0, 1'b0, 32'hFFC00001, 32'hFFC00001);
  endtask

  task automatic t_scale;
    res_case("R6 x2", 2'd1, 1'b0, 32'h3FC00000, 32'h40400000);
    res_case("R6 x4", 2'd2, 1'b0, 32'h3FC00000, 32'h40C00000);
    res_case("R6 div2", 2'd3, 1'b0, 32'h3FC00000, 32'h3F400000);
    res_case("R6 neg x2", 2'd1, 1'b0, 32'hC0400000, 32'hC0C00000);
  endtask

  task automatic t_overflow;
    res_case("R7 x2 top", 2'd1, 1'b0, 32'h7F000000, 32'h7F800000);
    res_case("R7 x4 neg max", 2'd2, 1'b0, 32'hFF7FFFFF, 32'hFF800000);
    res_case("R7 x4 exp253", 2'd2, 1'b0, 32'h7E800000, 32'h7F800000);
    res_case("R6 x4 exp252", 2'd2, 1'b0, 32'h7E000000, 32'h7F000000);
  endtask

  task automatic t_underflow;
    res_case("R8 div2 min", 2'd3, 1'b0, 32'h00800000, 32'h00000000);
    res_case("R8 div2 neg min", 2'd3, 1'b0, 32'h80800000, 32'h80000000);
    res_case("R8 sub x2", 2'd1, 1'b0, 32'h00400000, 32'h00000000);
    res_case("R8 neg sub x4", 2'd2, 1'b0, 32'h80000001, 32'h80000000);
  endtask

  task automatic t_special;
    res_case("R9 +0", 2'd1, 1'b0, 32'h00000000, 32'h00000000);
    res_case("R9 -0", 2'd2, 1'b0, 32'h80000000, 32'h80000000);
    res_case("R9 -inf", 2'd3, 1'b0, 32'hFF800000, 32'hFF800000);
    res_case("R9 nan", 2'd1, 1'b0, 32'h7FC00001, 32'h7FC00001);
  endtask

  task automatic t_clamp;
    res_case("R10 nan", 2'd0, 1'b1, 32'h7FC00000, 32'h00000000);
    res_case("R10 -0", 2'd0, 1'b1, 32'h80000000, 32'h00000000);
    res_case("R10 -1", 2'd0, 1'b1, 32'hBF800000, 32'h00000000);
    res_case("R10 2.0", 2'd0, 1'b1, 32'h40000000, 32'h3F800000);
    res_case("R10 +inf", 2'd0, 1'b1, 32'h7F800000, 32'h3F800000);
    res_case("R10 half", 2'd0, 1'b1, 32'h3F000000, 32'h3F000000);
    res_case("R10 one", 2'd0, 1'b1, 32'h3F800000, 32'h3F800000);
    res_case("R10 just above", 2'd0, 1'b1, 32'h3F800001, 32'h3F800000);
  endtask

  task automatic t_order;
    res_case("R11 0.75 x2", 2'd1, 1'b1, 32'h3F400000, 32'h3F800000);
    res_case("R11 1.5 div2", 2'd3, 1'b1, 32'h3FC00000, 32'h3F400000);
    res_case("R11 0.5 x2", 2'd1, 1'b1, 32'h3F000000, 32'h3F800000);
    res_case("R11 0.25 x2", 2'd1, 1'b1, 32'h3E800000, 32'h3F000000);
    res_case("R11 -2 x2", 2'd1, 1'b1, 32'hC0000000, 32'h00000000);
  endtask

  task automatic t_hold;
    beat(32'h11111111, 32'h22222222, 32'h33333333, '0, '0, 2'd0, 1'b0, 32'h44444444);
    src_i = '1; abs_i = '1; neg_i = '1; omod_i = 2'd1; clamp_i = 1'b1; res_i = 32'h40000000;
    repeat (3) @(negedge clk_i);
    chk("R12 valid", {31'd0, out_valid_o}, 32'd0);
    chk("R12 res", res_o, 32'h44444444);
    chk("R12 lane0", src_o[0*W +: W], 32'h11111111);
    chk("R12 lane2", src_o[2*W +: W], 32'h33333333);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    src_i = '0; abs_i = '0; neg_i = '0; omod_i = '0; clamp_i = 1'b0; res_i = '0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_valid();
    t_abs();
    t_neg();
    t_pass();
    t_scale();
    t_overflow();
    t_underflow();
    t_special();
    t_clamp();
    t_order();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule